// File: doc/BRIEF.md
# Double-Rate Half-Word Flash Fetch Adapter

This block connects a 32-bit core read bus, clocked at a base rate, to a flash array whose read port is only 16 bits wide and runs on a clock at twice that rate. The two clocks are phase-aligned, so every core period holds exactly two fast edges. For each core request the adapter issues one or two half-word reads. A 32-bit read takes one half-word in the first half of the core period and the next half-word in the second half. The assembled result is registered on the next core edge, so the core sees a fixed one-cycle read latency and never waits.

Requests carry a 2-bit size code: 00 for a byte, 01 for a half-word, 10 for a word, and 11, which is reserved. The flash occupies a physical window at `FLASH_BASE` (default 0x0008_0000) of `2**FLASH_AW` bytes (default 64 KiB). After reset, the same array is also visible at address zero, so the boot vector resolves into flash. Software can turn this alias off by writing a disable bit.

Bad requests return zero and raise an error flag in the same result cycle. A request is bad if it is misaligned, uses the reserved size code, or hits neither the physical window nor the enabled alias.

Top module: `half_fetch_adapter`

## Requirements
- R1: While reset is held and right after it, `rvalid`, `err` and `rdata` are zero. Reset clears the alias-disable bit, so the alias at zero works again after a reset even if it was disabled before.
- R2: A word read (size 10) at an address with bits 1:0 = 00 returns `{H[i+1], H[i]}` on the core edge after the request. Here H[i] is the half-word at half-word index i = address bits `FLASH_AW-1:1`, and the core sees no added cycles.
- R3: A half-word read (size 01) at an even address returns H[i], zero-extended to 32 bits, one core cycle after the request.
- R4: A byte read (size 00) returns H[i] bits 15:8 when address bit 0 is 1 and bits 7:0 when it is 0, zero-extended, one core cycle after the request.
- R5: A half-word read at an odd address, a word read with address bits 1:0 not 00, and any request with size 11 set `err` with `rdata` = 0 in the result cycle.
- R6: While the alias is enabled, an address below `2**FLASH_AW` returns the same data as the same offset inside the physical window.
- R7: Writing 1 to the alias-disable bit (`remap_wr` with `remap_wdata`=1) makes requests below `2**FLASH_AW` fail with `err` from the next cycle onward, while the physical window keeps working. Writing 0 restores the alias.
- R8: A request outside both the physical window and the enabled alias sets `err` and returns `rdata` = 0.
- R9: The flash port is enabled only for a good request. In the first half of the core period it carries index i. For a word, in the second half it carries index i+1. For a byte or half-word, the port is idle in the second half.
- R10: A core cycle without `req` gives `rvalid` = 0, `err` = 0 and `rdata` = 0 on the next core edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Core (base-rate) clock |
| clk_2x | input | 1 | Flash clock at twice the core rate, rising edges aligned with clk_core |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| req | input | 1 | Read request, held for one core period |
| addr | input | ADDR_W | Byte address of the request |
| size | input | 2 | 00 byte, 01 half-word, 10 word, 11 reserved |
| remap_wr | input | 1 | Write strobe for the alias-disable bit |
| remap_wdata | input | 1 | Value written to the alias-disable bit (1 = alias off) |
| rvalid | output | 1 | Result valid, one core cycle after req |
| err | output | 1 | Request was misaligned, reserved or outside flash |
| rdata | output | DW | Assembled, zero-extended read data |
| fl_en | output | 1 | Flash half-word read enable |
| fl_addr | output | FLASH_AW-1 | Flash half-word index |
| fl_rdata | input | HW | Flash half-word read data, valid within one fast period |

## Verification
Some properties are checked on every edge. On the core edge, each request produces a result on the next edge, an idle cycle gives quiet outputs, and an error always comes with blanked data. Misaligned and reserved requests always flag `err`, and narrow reads zero-extend. On the fast edge, a word request follows its first half-word index with the next index, and narrow requests leave the port idle in the second half.

Only the bench scenarios can show the rest. These are the actual data values assembled from two half-words, the byte-lane choice, the equivalence of aliased and physical reads, the effect of toggling the alias-disable bit, and a reset clearing that bit.

// File: rtl/half_fetch_pkg.sv
`timescale 1ns/1ps
package half_fetch_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } xfer_size_e;

   // True when the request cannot be served because of its alignment or size code.
   function automatic logic size_bad(input logic [1:0] sz, input logic [1:0] lsb);
      logic bad;
      unique case (xfer_size_e'(sz))
         SZ_BYTE: bad = 1'b0;
         SZ_HALF: bad = lsb[0];
         SZ_WORD: bad = (lsb != 2'b00);
         default: bad = 1'b1;
      endcase
      return bad;
   endfunction

endpackage

// File: rtl/ffa_decode.sv
`timescale 1ns/1ps
module ffa_decode
   import half_fetch_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          FLASH_AW   = 16,
   parameter logic [31:0] FLASH_BASE = 32'h0008_0000,
   parameter bit          ALIAS_EN   = 1'b1
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic [1:0]          size,
   input  logic                remap_off,
   output logic                ok,
   output logic [FLASH_AW-2:0] hw_idx
);
   localparam int TAG_W = ADDR_W - FLASH_AW;
   localparam logic [TAG_W-1:0] BASE_TAG = FLASH_BASE[ADDR_W-1:FLASH_AW];

   logic phys_hit;
   logic alias_hit;
   logic bad_shape;

   assign phys_hit = (addr[ADDR_W-1:FLASH_AW] == BASE_TAG);

   generate
      if (ALIAS_EN) begin : g_alias
         assign alias_hit = !remap_off && (addr[ADDR_W-1:FLASH_AW] == '0);
      end else begin : g_no_alias
         logic unused_remap;
         assign unused_remap = remap_off;
         assign alias_hit    = 1'b0;
      end
   endgenerate

   assign bad_shape = size_bad(size, addr[1:0]);
   assign ok        = (phys_hit || alias_hit) && !bad_shape;
   assign hw_idx    = addr[FLASH_AW-1:1];

endmodule

// File: rtl/ffa_phase.sv
`timescale 1ns/1ps
module ffa_phase #(
   parameter int HW = 16
) (
   input  logic          clk_2x,
   input  logic          rst_n,
   input  logic          core_tog,
   input  logic [HW-1:0] fl_rdata,
   output logic          high_half,
   output logic [HW-1:0] lo_q
);
   // seen_q trails the core toggle by one fast edge; they differ only in the
   // first half of each core period. Resetting it to 1 makes the very first
   // period after reset start in the low half as well.
   logic seen_q;

   always_ff @(posedge clk_2x) begin
      if (!rst_n) begin
         seen_q <= 1'b1;
      end else begin
         seen_q <= core_tog;
      end
   end

   assign high_half = (core_tog == seen_q);

   always_ff @(posedge clk_2x) begin
      if (!rst_n) begin
         lo_q <= '0;
      end else if (!high_half) begin
         lo_q <= fl_rdata;
      end
   end

endmodule

// File: rtl/ffa_assemble.sv
`timescale 1ns/1ps
module ffa_assemble
   import half_fetch_pkg::*;
#(
   parameter int HW = 16,
   parameter int DW = 32
) (
   input  logic [1:0]    size,
   input  logic          byte_hi,
   input  logic [HW-1:0] lo,
   input  logic [HW-1:0] hi,
   output logic [DW-1:0] data
);
   localparam int BW = HW / 2;

   logic [BW-1:0] lane;

   assign lane = byte_hi ? lo[HW-1:BW] : lo[BW-1:0];

   always_comb begin
      unique case (xfer_size_e'(size))
         SZ_BYTE: data = {{(DW-BW){1'b0}}, lane};
         SZ_HALF: data = {{(DW-HW){1'b0}}, lo};
         SZ_WORD: data = {hi, lo};
         default: data = '0;
      endcase
   end

endmodule

// File: rtl/half_fetch_adapter.sv
`timescale 1ns/1ps
module half_fetch_adapter
   import half_fetch_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          FLASH_AW   = 16,
   parameter logic [31:0] FLASH_BASE = 32'h0008_0000,
   parameter bit          ALIAS_EN   = 1'b1,
   parameter int          HW         = 16,
   parameter int          DW         = 32
) (
   input  logic                clk_core,
   input  logic                clk_2x,
   input  logic                rst_n,
   input  logic                req,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [1:0]          size,
   input  logic                remap_wr,
   input  logic                remap_wdata,
   output logic                rvalid,
   output logic                err,
   output logic [DW-1:0]       rdata,
   output logic                fl_en,
   output logic [FLASH_AW-2:0] fl_addr,
   input  logic [HW-1:0]       fl_rdata
);
   localparam int IDX_W = FLASH_AW - 1;

   // Elaboration-time parameter checks
   generate
      if (DW != 2 * HW) begin : g_bad_width
         $error("DW must be twice HW");
      end
      if (HW != 16) begin : g_bad_hw
         $error("flash half-word must be 16 bits");
      end
      if (FLASH_AW < 2 || FLASH_AW >= ADDR_W) begin : g_bad_aw
         $error("FLASH_AW out of range");
      end
      if ((FLASH_BASE & ((32'd1 << FLASH_AW) - 32'd1)) != 32'd0) begin : g_bad_base
         $error("FLASH_BASE must be aligned to the flash size");
      end
   endgenerate

   logic             tog_q;
   logic             remap_off_q;
   logic             ok;
   logic [IDX_W-1:0] hw_idx;
   logic             high_half;
   logic [HW-1:0]    lo_q;
   logic [DW-1:0]    asm_data;
   logic             is_word;

   ffa_decode #(
      .ADDR_W    (ADDR_W),
      .FLASH_AW  (FLASH_AW),
      .FLASH_BASE(FLASH_BASE),
      .ALIAS_EN  (ALIAS_EN)
   ) u_decode (
      .addr     (addr),
      .size     (size),
      .remap_off(remap_off_q),
      .ok       (ok),
      .hw_idx   (hw_idx)
   );

   ffa_phase #(
      .HW(HW)
   ) u_phase (
      .clk_2x   (clk_2x),
      .rst_n    (rst_n),
      .core_tog (tog_q),
      .fl_rdata (fl_rdata),
      .high_half(high_half),
      .lo_q     (lo_q)
   );

   ffa_assemble #(
      .HW(HW),
      .DW(DW)
   ) u_assemble (
      .size   (size),
      .byte_hi(addr[0]),
      .lo     (lo_q),
      .hi     (fl_rdata),
      .data   (asm_data)
   );

   assign is_word = (xfer_size_e'(size) == SZ_WORD);
   assign fl_en   = rst_n && req && ok && (!high_half || is_word);
   assign fl_addr = hw_idx + {{(IDX_W-1){1'b0}}, high_half & is_word};

   // Core-domain state: phase toggle, alias control and the result register.
   always_ff @(posedge clk_core) begin
      if (!rst_n) begin
         tog_q       <= 1'b0;
         remap_off_q <= 1'b0;
         rvalid      <= 1'b0;
         err         <= 1'b0;
         rdata       <= '0;
      end else begin
         tog_q  <= ~tog_q;
         if (remap_wr) begin
            remap_off_q <= remap_wdata;
         end
         rvalid <= req;
         err    <= req && !ok;
         rdata  <= (req && ok) ? asm_data : '0;
      end
   end

endmodule

// File: rtl/half_fetch_checker.sv
`timescale 1ns/1ps
module half_fetch_checker #(
   parameter int FLASH_AW = 16,
   parameter int HW       = 16,
   parameter int DW       = 32
) (
   input logic                clk_core,
   input logic                clk_2x,
   input logic                rst_n,
   input logic                req,
   input logic [1:0]          addr_lo,
   input logic [1:0]          size,
   input logic                rvalid,
   input logic                err,
   input logic [DW-1:0]       rdata,
   input logic                fl_en,
   input logic [FLASH_AW-2:0] fl_addr
);
   logic shape_bad;
   assign shape_bad = (size == 2'b11) ||
                      (size == 2'b01 && addr_lo[0]) ||
                      (size == 2'b10 && addr_lo != 2'b00);

   p_result_follows_req_r2: assert property (@(posedge clk_core) disable iff (!rst_n)
      req |=> rvalid);

   p_idle_quiet_r10: assert property (@(posedge clk_core) disable iff (!rst_n)
      !req |=> (!rvalid && !err && rdata == '0));

   p_err_blanks_data_r5: assert property (@(posedge clk_core) disable iff (!rst_n)
      err |-> (rdata == '0 && rvalid));

   p_misaligned_flags_r5: assert property (@(posedge clk_core) disable iff (!rst_n)
      (req && shape_bad) |=> err);

   p_half_zero_ext_r3: assert property (@(posedge clk_core) disable iff (!rst_n)
      (req && size == 2'b01) |=> (rdata[DW-1:HW] == '0));

   p_byte_zero_ext_r4: assert property (@(posedge clk_core) disable iff (!rst_n)
      (req && size == 2'b00) |=> (rdata[DW-1:8] == '0));

   // On a fast edge where clk_core was high beforehand, the first half has just ended.
   p_word_pair_r9: assert property (@(posedge clk_2x) disable iff (!rst_n)
      (clk_core && fl_en && req && size == 2'b10) |=>
         (fl_en && fl_addr == $past(fl_addr) + 1'b1));

   p_narrow_low_only_r9: assert property (@(posedge clk_2x) disable iff (!rst_n)
      (!clk_core && req && size != 2'b10) |-> !fl_en);

endmodule

bind half_fetch_adapter half_fetch_checker #(
   .FLASH_AW(FLASH_AW),
   .HW      (HW),
   .DW      (DW)
) u_chk (
   .clk_core(clk_core),
   .clk_2x  (clk_2x),
   .rst_n   (rst_n),
   .req     (req),
   .addr_lo (addr[1:0]),
   .size    (size),
   .rvalid  (rvalid),
   .err     (err),
   .rdata   (rdata),
   .fl_en   (fl_en),
   .fl_addr (fl_addr)
);

// File: tb/half_fetch_adapter_bench.sv
`timescale 1ns/1ps
module half_fetch_adapter_bench;

   typedef struct {
      logic        v;
      logic        e;
      logic [31:0] d;
      string       tag;
   } exp_t;

   logic        clk_core;
   logic        clk_2x;
   logic        rst_n;
   logic        req;
   logic [31:0] addr;
   logic [1:0]  size;
   logic        remap_wr;
   logic        remap_wdata;
   logic        rvalid;
   logic        err;
   logic [31:0] rdata;
   logic        fl_en;
   logic [14:0] fl_addr;
   logic [15:0] fl_rdata;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   mon_en  = 0;
   bit   done    = 0;
   logic roff_model = 0;
   exp_t sb[$];

   half_fetch_adapter u_half_fetch_adapter (
      .clk_core   (clk_core),
      .clk_2x     (clk_2x),
      .rst_n      (rst_n),
      .req        (req),
      .addr       (addr),
      .size       (size),
      .remap_wr   (remap_wr),
      .remap_wdata(remap_wdata),
      .rvalid     (rvalid),
      .err        (err),
      .rdata      (rdata),
      .fl_en      (fl_en),
      .fl_addr    (fl_addr),
      .fl_rdata   (fl_rdata)
   );

   // 200 MHz flash clock; core clock at half rate, rising edges aligned.
   initial begin
      clk_2x = 1'b1;
      forever #2.5 clk_2x = ~clk_2x;
   end
   initial begin
      clk_core = 1'b0;
      forever #5 clk_core = ~clk_core;
   end

   function automatic logic [15:0] hwv(input logic [14:0] i);
      logic [31:0] p;
      p = {17'd0, i} * 32'h0000_9E37;
      return p[15:0] ^ 16'h5A3C ^ {i[6:0], i[14:6]};
   endfunction

   assign fl_rdata = fl_en ? hwv(fl_addr) : 16'hDEAD;

   function automatic void model(input logic [31:0] a, input logic [1:0] s, input logic roff,
                                 output logic ok, output logic [31:0] d, output logic [14:0] idx);
      logic hit, mis;
      hit = (a[31:16] == 16'h0008) || (!roff && a[31:16] == 16'h0000);
      mis = (s == 2'b11) || (s == 2'b01 && a[0]) || (s == 2'b10 && a[1:0] != 2'b00);
      idx = a[15:1];
      ok  = hit && !mis;
      case (s)
         2'b00:   d = a[0] ? {24'd0, hwv(idx)[15:8]} : {24'd0, hwv(idx)[7:0]};
         2'b01:   d = {16'd0, hwv(idx)};
         2'b10:   d = {hwv(idx + 15'd1), hwv(idx)};
         default: d = 32'd0;
      endcase
      if (!ok) d = 32'd0;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // Monitor: pops the item pushed in the previous core period.
   always @(posedge clk_core) begin
      exp_t x;
      #3;
      if (mon_en && sb.size() > 0) begin
         x = sb.pop_front();
         chk(x.tag, "rvalid", {31'd0, rvalid}, {31'd0, x.v});
         chk(x.tag, "err",    {31'd0, err},    {31'd0, x.e});
         chk(x.tag, "rdata",  rdata,           x.d);
      end
   end

   task automatic drive(input logic v, input logic [31:0] a, input logic [1:0] s, input string tag);
      logic        ok;
      logic [31:0] d;
      logic [14:0] idx;
      exp_t        x;
      @(posedge clk_core);
      #1;
      req = v; addr = a; size = s; remap_wr = 1'b0;
      model(a, s, roff_model, ok, d, idx);
      #1;  // first half of the core period
      chk("R9", "fl_en first half", {31'd0, fl_en}, {31'd0, v && ok});
      if (v && ok) chk("R9", "fl_addr first half", {17'd0, fl_addr}, {17'd0, idx});
      #5;  // second half of the core period
      chk("R9", "fl_en second half", {31'd0, fl_en}, {31'd0, v && ok && s == 2'b10});
      if (v && ok && s == 2'b10) chk("R9", "fl_addr second half", {17'd0, fl_addr}, {17'd0, idx + 15'd1});
      x.v = v; x.e = v && !ok; x.d = v ? d : 32'd0; x.tag = tag;
      sb.push_back(x);
   endtask

   task automatic set_remap(input logic val);
      exp_t x;
      @(posedge clk_core);
      #1;
      req = 1'b0; remap_wr = 1'b1; remap_wdata = val;
      #6;
      x.v = 1'b0; x.e = 1'b0; x.d = 32'd0; x.tag = "R10";
      sb.push_back(x);
      roff_model = val;
   endtask

   task automatic do_reset();
      mon_en = 0;
      @(posedge clk_core);
      #1;
      rst_n = 1'b0; req = 1'b0; remap_wr = 1'b0;
      repeat (3) @(posedge clk_core);
      #3;
      chk("R1", "rvalid in reset", {31'd0, rvalid}, 32'd0);
      chk("R1", "err in reset",    {31'd0, err},    32'd0);
      chk("R1", "rdata in reset",  rdata,           32'd0);
      @(posedge clk_core);
      #1;
      rst_n = 1'b1;
      sb.delete();
      roff_model = 1'b0;
      mon_en = 1;
   endtask

   initial begin
      rst_n = 1'b0; req = 1'b0; addr = '0; size = 2'b00;
      remap_wr = 1'b0; remap_wdata = 1'b0;
      do_reset();

      drive(1'b0, 32'h0, 2'b00, "R10");
      // R2 words in the physical window
      drive(1'b1, 32'h0008_0000, 2'b10, "R2");
      drive(1'b1, 32'h0008_0004, 2'b10, "R2");
      drive(1'b1, 32'h0008_FFFC, 2'b10, "R2");
      // R3 half-words
      drive(1'b1, 32'h0008_0002, 2'b01, "R3");
      drive(1'b1, 32'h0008_ABC6, 2'b01, "R3");
      // R4 bytes, both lanes
      drive(1'b1, 32'h0008_0001, 2'b00, "R4");
      drive(1'b1, 32'h0008_0000, 2'b00, "R4");
      drive(1'b1, 32'h0008_0FF3, 2'b00, "R4");
      drive(1'b0, 32'h0008_0000, 2'b10, "R10");
      // R6 alias at zero mirrors the physical window
      drive(1'b1, 32'h0000_0000, 2'b10, "R6");
      drive(1'b1, 32'h0000_0002, 2'b01, "R6");
      drive(1'b1, 32'h0000_FFFF, 2'b00, "R6");
      drive(1'b1, 32'h0000_1234, 2'b10, "R6");
      // R5 misaligned and reserved
      drive(1'b1, 32'h0008_0001, 2'b01, "R5");
      drive(1'b1, 32'h0008_0002, 2'b10, "R5");
      drive(1'b1, 32'h0000_0003, 2'b10, "R5");
      drive(1'b1, 32'h0008_0000, 2'b11, "R5");
      // R8 outside flash
      drive(1'b1, 32'h0009_0000, 2'b10, "R8");
      drive(1'b1, 32'h0007_FFFE, 2'b01, "R8");
      drive(1'b1, 32'hFFFF_0000, 2'b00, "R8");
      // R7 alias disable and restore
      set_remap(1'b1);
      drive(1'b1, 32'h0000_0000, 2'b10, "R7");
      drive(1'b1, 32'h0008_0000, 2'b10, "R7");
      drive(1'b1, 32'h0000_0005, 2'b00, "R7");
      set_remap(1'b0);
      drive(1'b1, 32'h0000_0000, 2'b10, "R7");
      // R1 reset clears the disable bit
      set_remap(1'b1);
      drive(1'b1, 32'h0000_0010, 2'b10, "R7");
      do_reset();
      drive(1'b1, 32'h0000_0010, 2'b10, "R1");
      drive(1'b1, 32'h0000_0011, 2'b00, "R1");
      drive(1'b0, 32'h0, 2'b00, "R10");
      @(posedge clk_core);
      #5;
      chk("R10", "scoreboard drained", sb.size(), 32'd0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule